// File: doc/BRIEF.md
# Pulse-Swallow Programmable Divider

This block divides its input clock (the VCO-derived clock of a frequency synthesizer loop) by a programmable 15-bit ratio N. It emits one single-cycle pulse every N input cycles. That pulse is the comparison signal fed to the phase detector. With an 8x fixed front division and a 3.90625 kHz reference, the loop then settles at a VCO frequency of 31.25 kHz times N.

Internally the division uses the dual-modulus method, not a flat modulo-N counter. A prescaler counts either 33 or 32 input cycles per period. A 5-bit swallow counter is loaded from the five low bits of N, and a 10-bit main counter is loaded from the ten high bits. While the swallow count is non-zero the prescaler runs at 33. After that it runs at 32 until the main count is exhausted. One division cycle therefore lasts 33·A + 32·(M−A) = 32·M + A = N cycles.

The ratio input is sampled only at the boundary between division cycles. Ratios below 1024 are raised to 1024, so that the main count always covers the swallow count.

The control state machine has three states:
- RELOAD: entered only from reset. It loads the counters and leaves on the next edge.
- SWALLOW: the prescaler runs at 33.
- MAIN: the prescaler runs at 32.

It has four transitions:
- RELOAD→SWALLOW when the new A is non-zero.
- RELOAD→MAIN when the new A is zero.
- SWALLOW→MAIN when the last swallow period ends.
- End of cycle: from MAIN, when the last main period ends, the counters reload and the machine enters SWALLOW or MAIN according to the new A.

Top module: `pulse_swallow_div`

## Requirements
- R1: While rst_n is low, div_pulse is 0, and it stays 0 until the first division cycle completes.
- R2: With ratio_in held at N (1024 ≤ N ≤ 32767), consecutive rising edges of div_pulse are exactly N clock cycles apart.
- R3: div_pulse is high for exactly one clock cycle per division cycle.
- R4: The period is 32·M + A, where M = ratio_in[14:5] and A = ratio_in[4:0], for every A from 0 to 31.
- R5: A ratio_in below 1024, including 0, divides by exactly 1024.
- R6: A change of ratio_in inside a division cycle does not alter that cycle. The value present on the edge on which div_pulse rises sets the length of the following cycle.
- R7: After reset is released, the first edge with rst_n high loads ratio_in, and div_pulse rises on the N-th edge after that one.
- R8: The largest ratio, 32767, divides by exactly 32767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided (VCO-derived) |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_in | input | 15 | Division ratio N, sampled at cycle boundaries |
| div_pulse | output | 1 | One-cycle pulse per N input cycles |

## Verification
Any wrong internal state shows up at the ports as a misplaced pulse. A prescaler loaded with the wrong modulus, a swallow counter off by one, or a wrong state transition shifts the next pulse by one or more cycles. The fault is therefore visible at most one division period (at most 32767 cycles) after it occurs. A stuck counter shows as a missing pulse, and a doubled end condition shows as a pulse two cycles wide. A per-cycle reference model of the expected pulse train catches each of these in the cycle where the first pulse is early, late or missing.

// File: rtl/psd_pkg.sv
package psd_pkg;
    localparam int SWALLOW_W = 5;
    localparam int MAIN_W    = 10;

    typedef enum logic [1:0] {
        ST_RELOAD  = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_MAIN    = 2'd2
    } psd_state_t;
endpackage

// File: rtl/psd_prescaler.sv
// Dual-modulus prescaler modelled as a down counter on the input clock.
module psd_prescaler #(
    parameter int PRE_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             sel_long,
    output logic             period_end,
    output logic [PRE_W-1:0] count
);
    localparam logic [PRE_W-1:0] LONG_LOAD  = PRE_W'(1 << (PRE_W - 1));
    localparam logic [PRE_W-1:0] SHORT_LOAD = PRE_W'((1 << (PRE_W - 1)) - 1);

    logic [PRE_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || cnt_q == '0) begin
            cnt_q <= sel_long ? LONG_LOAD : SHORT_LOAD;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign period_end = (cnt_q == '0);
    assign count      = cnt_q;
endmodule

// File: rtl/psd_down_counter.sv
// Loadable down counter used for both the swallow and the main count.
module psd_down_counter #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] count,
    output logic         at_one
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign count  = cnt_q;
    assign at_one = (cnt_q == W'(1));
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
    import psd_pkg::*;
#(
    parameter int SW_W = SWALLOW_W,
    parameter int MN_W = MAIN_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SW_W+MN_W-1:0] ratio_in,
    output logic                 div_pulse
);
    localparam int RATIO_W   = SW_W + MN_W;
    localparam int PRE_W     = SW_W + 1;
    localparam int MIN_RATIO = 1 << (2 * SW_W);

    psd_state_t state_q, state_d;

    logic [RATIO_W-1:0] eff_ratio;
    logic [SW_W-1:0]    a_new;
    logic [MN_W-1:0]    m_new;
    logic               load;
    logic               pre_end, pre_tc;
    logic               cyc_end;
    logic               mod_sel;
    logic [PRE_W-1:0]   pre_cnt;
    logic [SW_W-1:0]    a_cnt;
    logic [MN_W-1:0]    m_cnt;
    logic               a_one, m_one;
    logic               pulse_q;

    // Ratio clamp and split into swallow and main fields.
    always_comb begin
        if (ratio_in < RATIO_W'(MIN_RATIO)) begin
            eff_ratio = RATIO_W'(MIN_RATIO);
        end else begin
            eff_ratio = ratio_in;
        end
        a_new = eff_ratio[SW_W-1:0];
        m_new = eff_ratio[RATIO_W-1:SW_W];
    end

    assign pre_end = pre_tc && (state_q != ST_RELOAD);
    assign cyc_end = (state_q == ST_MAIN) && pre_end && m_one;
    assign load    = (state_q == ST_RELOAD) || cyc_end;

    // Modulus for the next prescaler period.
    always_comb begin
        if (load) begin
            mod_sel = (a_new != '0);
        end else begin
            mod_sel = (state_q == ST_SWALLOW) && !a_one;
        end
    end

    psd_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (load),
        .sel_long   (mod_sel),
        .period_end (pre_tc),
        .count      (pre_cnt)
    );

    psd_down_counter #(.W(SW_W)) u_swallow (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (a_new),
        .dec      (pre_end && (state_q == ST_SWALLOW)),
        .count    (a_cnt),
        .at_one   (a_one)
    );

    psd_down_counter #(.W(MN_W)) u_main (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (m_new),
        .dec      (pre_end),
        .count    (m_cnt),
        .at_one   (m_one)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RELOAD: begin
                state_d = (a_new != '0) ? ST_SWALLOW : ST_MAIN;
            end
            ST_SWALLOW: begin
                if (pre_end && a_one) begin
                    state_d = ST_MAIN;
                end
            end
            ST_MAIN: begin
                if (cyc_end) begin
                    state_d = (a_new != '0) ? ST_SWALLOW : ST_MAIN;
                end
            end
            default: state_d = ST_RELOAD;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RELOAD;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= cyc_end;
        end
    end

    assign div_pulse = pulse_q;
endmodule

// File: rtl/pulse_swallow_div_chk.sv
module pulse_swallow_div_chk
    import psd_pkg::*;
#(
    parameter int SW_W = SWALLOW_W,
    parameter int MN_W = MAIN_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              div_pulse,
    input psd_state_t        state_q,
    input logic [SW_W:0]     pre_cnt,
    input logic [SW_W-1:0]   a_cnt,
    input logic [MN_W-1:0]   m_cnt
);
    localparam logic [SW_W:0] PRE_MAX = (SW_W+1)'(1 << SW_W);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> !div_pulse);

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);

    assert_pulse_at_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |-> $past(state_q == ST_MAIN && m_cnt == MN_W'(1) && pre_cnt == '0));

    assert_swallow_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SWALLOW) |-> (a_cnt != '0));

    assert_main_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RELOAD) |-> (m_cnt != '0));

    assert_pre_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pre_cnt <= PRE_MAX);
endmodule

bind pulse_swallow_div pulse_swallow_div_chk #(.SW_W(SW_W), .MN_W(MN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_pulse (div_pulse),
    .state_q   (state_q),
    .pre_cnt   (pre_cnt),
    .a_cnt     (a_cnt),
    .m_cnt     (m_cnt)
);

// File: tb/tb_pulse_swallow_div.sv
`timescale 1ns/1ps
module tb_pulse_swallow_div;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] ratio_in = 15'd2000;
    logic        div_pulse;

    int    checks = 0;
    int    fails = 0;
    int    cycles = 0;
    string tag = "R1";

    // Reference model state.
    bit started = 0;
    bit exp_pulse = 0;
    int cur_n = 0;
    int cnt = 0;

    pulse_swallow_div dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ratio_in  (ratio_in),
        .div_pulse (div_pulse)
    );

    always #10 clk = ~clk;

    function automatic int clamp_ratio(input int r);
        return (r < 1024) ? 1024 : r;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            started   = 0;
            exp_pulse = 0;
            cnt       = 0;
        end else if (!started) begin
            started   = 1;
            cur_n     = clamp_ratio(int'(ratio_in));
            cnt       = 0;
            exp_pulse = 0;
        end else begin
            cnt++;
            if (cnt == cur_n) begin
                exp_pulse = 1;
                cur_n     = clamp_ratio(int'(ratio_in));
                cnt       = 0;
            end else begin
                exp_pulse = 0;
            end
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        checks++;
        if (div_pulse !== exp_pulse) begin
            fails++;
            $display("FAIL %s cycle %0d: div_pulse=%0b expected %0b", tag, cycles, div_pulse, exp_pulse);
        end
    end

    always @(negedge clk) begin
        if (cycles > 190000) begin
            fails++;
            $display("FAIL watchdog: run hung at cycle %0d, expected completion", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks + 1);
            $finish;
        end
    end

    task automatic wait_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (!div_pulse) @(negedge clk);
        end
    endtask

    task automatic run_ratio(input int r, input int n, input string t);
        @(negedge clk);
        tag      = t;
        ratio_in = 15'(r);
        wait_pulses(n);
    endtask

    initial begin
        // R1: output quiet in reset
        tag = "R1";
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R7: first pulse timing after reset release
        tag = "R7";
        wait_pulses(1);
        // R2: steady ratios
        run_ratio(1100, 2, "R2");
        run_ratio(1537, 2, "R2");
        // R4: swallow field extremes
        run_ratio(1055, 3, "R4");
        run_ratio(2048, 3, "R4");
        run_ratio(4095, 2, "R4");
        // R5: clamping below the minimum
        run_ratio(0, 2, "R5");
        run_ratio(1023, 2, "R5");
        // R6: mid-cycle change only applies at the boundary
        run_ratio(1500, 1, "R6");
        repeat (300) @(negedge clk);
        ratio_in = 15'd2600;
        wait_pulses(3);
        // R8: largest ratio
        run_ratio(32767, 2, "R8");
        // R3: random ratios, pulse width checked every cycle
        for (int k = 0; k < 8; k++) begin
            run_ratio(int'($urandom_range(6000, 1024)), 1, "R3");
        end
        repeat (5) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule